// File: doc/BRIEF.md
# Frame Sync Protection Unit

This block watches the frame-sync detections that a pattern matcher finds in a recovered channel-bit stream. It turns them into a steady, protected frame reference. Each channel-clock enable is one tick. A raw detection is taken only on a tick. Once the block holds a frame phase, it opens a timing window around the position where the next sync is due. Detections outside that window are ignored. When the window closes with no detection, the block supplies a synthetic sync in its place.

Two counters with different limits decide when to give up on the held phase. Once a sync has been confirmed, up to 13 inserted syncs in a row are tolerated. Just after a resync, only a short run of misses is allowed. Either way, the block then drops back to hunting and takes the next raw detection it sees. A slow sampler turns the sync-good flag into a spindle lock flag. The flag rises at once but falls only after a run of bad samples.

All pins are plain control and status levels or single-cycle strobes qualified by the channel-clock enable. No stream carries data, so there is no valid/ready pair and no back-pressure. The frame strobe cannot be stalled, and whatever consumes it must take it in the cycle it is high.

Top module: `frame_sync_guard`

## Requirements
- R1: While reset is asserted and after it is released, frame_strobe, sync_good, prot_mon and spin_lock are all low, and the block is hunting.
- R2: While hunting (prot_mon low), the first raw sync seen on a tick is accepted wherever it falls. On the next clock, frame_strobe pulses, prot_mon goes high and sync_good stays low.
- R3: While protected, a raw sync is accepted when it arrives between FRAME_LEN-H and FRAME_LEN+H-1 ticks after the last reference (accepted or inserted sync, taken at its nominal position). H is 13 when win_wide is 1 and 3 when win_wide is 0, which gives windows 26 and 6 ticks wide. An accepted sync pulses frame_strobe.
- R4: While protected, a raw sync outside the window is ignored. It gives no strobe and does not restart the frame counter, so a sync at the original nominal position is still accepted afterwards.
- R5: sync_good goes high on an accepted in-window sync. It goes low when a window closes without a sync. It is never high while hunting.
- R6: When a window closes without a sync and protection is not exhausted, a synthetic sync is inserted. frame_strobe pulses on the closing tick, and the next nominal position lies FRAME_LEN ticks after the previous nominal one.
- R7: After a sync has been confirmed, at most 13 syncs are inserted in a row. The 14th consecutive empty window releases protection: there is no strobe and prot_mon goes low.
- R8: After a resync from hunting, and before any in-window sync, the first two empty windows insert syncs. The third empty window releases protection. An in-window sync in between switches the block to the 13-frame rule.
- R9: sync_good is sampled once every LOCK_DIV ticks (460 Hz at the nominal channel clock). spin_lock rises after a high sample and falls only after 8 consecutive low samples.
- R10: On clock cycles with chan_en low, raw_sync is ignored and no counter or state advances.
- R11: frame_strobe is registered: it is high for exactly one clock, one clock after the tick that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel-clock enable; one tick per channel bit |
| raw_sync | input | 1 | Raw sync detection from the pattern matcher, valid with chan_en |
| win_wide | input | 1 | Window select: 1 = 26-tick window, 0 = 6-tick window |
| frame_strobe | output | 1 | One-clock pulse per accepted or inserted frame sync |
| sync_good | output | 1 | High while the last window saw a properly timed sync |
| prot_mon | output | 1 | High while the window is enforced, low while hunting |
| spin_lock | output | 1 | Slow-sampled lock flag with an 8-sample release delay |

## Verification
The assertions assume that reset is held low across at least one clock edge. They also assume that raw_sync carries meaning only on cycles where chan_en is high, so a pulse without an enable must not be expected to move anything. The bench changes inputs only on falling clock edges. It changes win_wide only while reset is held, because moving it mid-frame would shift a window that is already open. Stimulus places syncs at exact tick distances from the last reference. Those distances are swept one tick past each window edge for both widths, and runs of empty windows are long enough to cross both protection limits and the lock release delay.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } fsp_state_e;
endpackage

// File: rtl/fsp_window.sv
module fsp_window #(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_WIDE   = 26,
  parameter int WIN_NARROW = 6,
  parameter int CW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          win_wide,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] half,
  output logic          in_win,
  output logic          win_close
);
  // counter value seen on the tick that lies FRAME_LEN ticks after a reference
  localparam logic [CW-1:0] NOM     = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FRAME_LEN - 1 + WIN_WIDE / 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lo;
  logic [CW-1:0] hi;

  always_comb begin
    half      = win_wide ? CW'(WIN_WIDE / 2) : CW'(WIN_NARROW / 2);
    lo        = NOM - half;
    hi        = NOM + half - CW'(1);
    in_win    = (cnt >= lo) && (cnt <= hi);
    win_close = (cnt == hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (chan_en) begin
      if (reload) begin
        cnt <= reload_val;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fsp_guard.sv
module fsp_guard
  import fsp_pkg::*;
#(
  parameter int FWD_LIMIT = 13,
  parameter int BWD_LIMIT = 3,
  parameter int CW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          raw_sync,
  input  logic          in_win,
  input  logic          win_close,
  input  logic [CW-1:0] half,
  output logic          reload,
  output logic [CW-1:0] reload_val,
  output logic          frame_strobe,
  output logic          sync_good,
  output logic          prot_mon
);
  localparam int MW = $clog2(FWD_LIMIT + 1);
  localparam logic [MW-1:0] FWD_LAST = MW'(FWD_LIMIT);
  localparam logic [MW-1:0] BWD_LAST = MW'(BWD_LIMIT - 1);

  fsp_state_e    state;
  logic [MW-1:0] miss_run;
  logic          prot;
  logic          acq;
  logic          hit;
  logic          miss;
  logic          release_now;
  logic          insert;

  always_comb begin
    prot        = (state != ST_HUNT);
    acq         = !prot && raw_sync;
    hit         = prot && raw_sync && in_win;
    miss        = prot && win_close && !raw_sync;
    release_now = miss && ((state == ST_LOCKED) ? (miss_run == FWD_LAST)
                                                : (miss_run == BWD_LAST));
    insert      = miss && !release_now;
    reload      = chan_en && (acq || hit || insert);
    reload_val  = insert ? (half - CW'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_HUNT;
      miss_run     <= '0;
      frame_strobe <= 1'b0;
      sync_good    <= 1'b0;
    end else begin
      frame_strobe <= chan_en && (acq || hit || insert);
      if (chan_en) begin
        if (acq) begin
          state    <= ST_CONFIRM;
          miss_run <= '0;
        end else if (hit) begin
          state     <= ST_LOCKED;
          miss_run  <= '0;
          sync_good <= 1'b1;
        end else if (miss) begin
          sync_good <= 1'b0;
          if (release_now) begin
            state    <= ST_HUNT;
            miss_run <= '0;
          end else begin
            miss_run <= miss_run + MW'(1);
          end
        end
      end
    end
  end

  assign prot_mon = prot;
endmodule

// File: rtl/fsp_lock.sv
module fsp_lock #(
  parameter int LOCK_DIV = 9395,
  parameter int LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic good,
  output logic lock
);
  localparam int DW = $clog2(LOCK_DIV);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(LOCK_DIV - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);

  logic [DW-1:0] div;
  logic [RW-1:0] low_run;
  logic          sample;

  assign sample = chan_en && (div == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      low_run <= '0;
      lock    <= 1'b0;
    end else begin
      if (chan_en) begin
        div <= sample ? '0 : div + DW'(1);
      end
      if (sample) begin
        if (good) begin
          lock    <= 1'b1;
          low_run <= '0;
        end else if (low_run == RUN_LAST) begin
          lock <= 1'b0;
        end else begin
          low_run <= low_run + RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frame_sync_guard.sv
module frame_sync_guard #(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_WIDE   = 26,
  parameter int WIN_NARROW = 6,
  parameter int FWD_LIMIT  = 13,
  parameter int BWD_LIMIT  = 3,
  parameter int LOCK_DIV   = 9395,
  parameter int LOCK_RUN   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic raw_sync,
  input  logic win_wide,
  output logic frame_strobe,
  output logic sync_good,
  output logic prot_mon,
  output logic spin_lock
);
  localparam int CW = $clog2(FRAME_LEN + WIN_WIDE);

  logic [CW-1:0] half;
  logic [CW-1:0] reload_val;
  logic          reload;
  logic          in_win;
  logic          win_close;

  fsp_window #(
    .FRAME_LEN (FRAME_LEN),
    .WIN_WIDE  (WIN_WIDE),
    .WIN_NARROW(WIN_NARROW),
    .CW        (CW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .win_wide  (win_wide),
    .reload    (reload),
    .reload_val(reload_val),
    .half      (half),
    .in_win    (in_win),
    .win_close (win_close)
  );

  fsp_guard #(
    .FWD_LIMIT(FWD_LIMIT),
    .BWD_LIMIT(BWD_LIMIT),
    .CW       (CW)
  ) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .raw_sync    (raw_sync),
    .in_win      (in_win),
    .win_close   (win_close),
    .half        (half),
    .reload      (reload),
    .reload_val  (reload_val),
    .frame_strobe(frame_strobe),
    .sync_good   (sync_good),
    .prot_mon    (prot_mon)
  );

  fsp_lock #(
    .LOCK_DIV(LOCK_DIV),
    .LOCK_RUN(LOCK_RUN)
  ) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .chan_en(chan_en),
    .good   (sync_good),
    .lock   (spin_lock)
  );
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker (
  input logic clk,
  input logic rst_n,
  input logic chan_en,
  input logic raw_sync,
  input logic frame_strobe,
  input logic sync_good,
  input logic prot_mon,
  input logic spin_lock
);
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);

  p_good_needs_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_good |-> prot_mon);

  p_entry_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_mon) |-> frame_strobe);

  p_hunt_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !$past(prot_mon)) |-> $past(raw_sync && chan_en));

  p_lock_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spin_lock) |-> $past(sync_good));

  p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spin_lock) |-> !$past(sync_good));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!frame_strobe && $stable(prot_mon) && $stable(sync_good)
                  && $stable(spin_lock)));
endmodule

bind frame_sync_guard fsp_checker u_fsp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en     (chan_en),
  .raw_sync    (raw_sync),
  .frame_strobe(frame_strobe),
  .sync_good   (sync_good),
  .prot_mon    (prot_mon),
  .spin_lock   (spin_lock)
);

// File: tb/frame_sync_guard_bench.sv
module frame_sync_guard_bench;
  localparam int FL = 40;
  localparam int WW = 10;
  localparam int WN = 4;
  localparam int LD = 20;
  localparam int LR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0;
  logic raw_sync = 1'b0;
  logic win_wide = 1'b0;
  logic frame_strobe, sync_good, prot_mon, spin_lock;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int en_ticks = 0;
  int low_run = 0;
  logic exp_lock = 1'b0;
  logic prev_good = 1'b0;

  always #10 clk = ~clk;

  frame_sync_guard #(
    .FRAME_LEN(FL), .WIN_WIDE(WW), .WIN_NARROW(WN),
    .FWD_LIMIT(13), .BWD_LIMIT(3), .LOCK_DIV(LD), .LOCK_RUN(LR)
  ) u_frame_sync_guard (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .raw_sync(raw_sync),
    .win_wide(win_wide), .frame_strobe(frame_strobe), .sync_good(sync_good),
    .prot_mon(prot_mon), .spin_lock(spin_lock)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock; outputs sampled 1 ns after the edge; lock expectation from R9
  task automatic step(input logic en, input logic s);
    @(negedge clk);
    chan_en  = en;
    raw_sync = s;
    @(posedge clk);
    #1;
    if (en) begin
      en_ticks++;
      if (en_ticks % LD == 0) begin
        if (prev_good) begin
          exp_lock = 1'b1;
          low_run  = 0;
        end else begin
          if (low_run < LR) low_run++;
          if (low_run >= LR) exp_lock = 1'b0;
        end
      end
    end
    chk("R9 lock level", int'(spin_lock), int'(exp_lock));
    prev_good = sync_good;
  endtask

  task automatic idle(input int n, input string req);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      if (frame_strobe) seen = 1'b1;
    end
    chk(req, int'(seen), 0);
  endtask

  task automatic do_reset(input logic w);
    @(negedge clk);
    rst_n    = 1'b0;
    chan_en  = 1'b0;
    raw_sync = 1'b0;
    win_wide = w;
    repeat (2) @(negedge clk);
    chk("R1 strobe in reset", int'(frame_strobe), 0);
    chk("R1 prot in reset", int'(prot_mon), 0);
    rst_n     = 1'b1;
    en_ticks  = 0;
    low_run   = 0;
    exp_lock  = 1'b0;
    prev_good = 1'b0;
  endtask

  initial begin
    int h;
    // R1 reset state
    do_reset(1'b0);
    chk("R1 strobe", int'(frame_strobe), 0);
    chk("R1 good", int'(sync_good), 0);
    chk("R1 prot", int'(prot_mon), 0);
    chk("R1 lock", int'(spin_lock), 0);

    // R10 syncs without enable are ignored while hunting
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1);
      chk("R10 no strobe without enable", int'(frame_strobe), 0);
      chk("R10 still hunting", int'(prot_mon), 0);
    end
    // R2 acquisition anywhere
    step(1'b1, 1'b1);
    chk("R2 strobe on acquire", int'(frame_strobe), 1);
    chk("R2 prot after acquire", int'(prot_mon), 1);
    chk("R2 good stays low", int'(sync_good), 0);
    step(1'b1, 1'b0);
    chk("R11 strobe one clock", int'(frame_strobe), 0);

    // R3/R4/R5 window edge sweep for both widths
    for (int w = 0; w < 2; w++) begin
      h = (w == 1) ? WW / 2 : WN / 2;
      for (int d = -h - 1; d < h; d++) begin
        do_reset(w == 1);
        step(1'b1, 1'b1);
        chk("R2 acquire in sweep", int'(prot_mon), 1);
        idle(FL + d - 1, "R3 no strobe before sync");
        step(1'b1, 1'b1);
        chk("R3 R4 window accept", int'(frame_strobe), (d >= -h) ? 1 : 0);
        chk("R5 good on in-window sync", int'(sync_good), (d >= -h) ? 1 : 0);
        if (d < -h) begin
          idle(-d - 1, "R4 ignored sync gives no strobe");
          step(1'b1, 1'b1);
          chk("R4 nominal still accepted", int'(frame_strobe), 1);
          chk("R4 good at nominal", int'(sync_good), 1);
        end
      end
    end

    // R6 insertion and rephase, narrow window (h = 2)
    h = WN / 2;
    do_reset(1'b0);
    step(1'b1, 1'b1);
    idle(FL - 1, "R3 quiet frame");
    step(1'b1, 1'b1);
    chk("R5 good after hit", int'(sync_good), 1);
    idle(FL + h - 2, "R6 no early insert");
    chk("R9 lock up after good samples", int'(spin_lock), 1);
    step(1'b1, 1'b0);
    chk("R6 insert strobe", int'(frame_strobe), 1);
    chk("R5 good cleared on miss", int'(sync_good), 0);
    chk("R6 prot kept", int'(prot_mon), 1);
    idle(FL - h, "R6 quiet after insert");
    step(1'b1, 1'b1);
    chk("R6 nominal after insert", int'(frame_strobe), 1);
    chk("R6 good after rephase", int'(sync_good), 1);

    // R7 forward limit from locked state
    for (int k = 1; k <= 14; k++) begin
      idle((k == 1) ? FL + h - 2 : FL - 1, "R7 quiet between closes");
      step(1'b1, 1'b0);
      chk("R7 insert or release strobe", int'(frame_strobe), (k <= 13) ? 1 : 0);
      chk("R7 protection state", int'(prot_mon), (k <= 13) ? 1 : 0);
    end
    chk("R9 lock dropped after low run", int'(spin_lock), 0);

    // R8 backward limit after resync, wide window (h = 5)
    h = WW / 2;
    do_reset(1'b1);
    step(1'b1, 1'b1);
    for (int k = 1; k <= 3; k++) begin
      idle((k == 1) ? FL + h - 2 : FL - 1, "R8 quiet between closes");
      step(1'b1, 1'b0);
      chk("R8 insert or release strobe", int'(frame_strobe), (k <= 2) ? 1 : 0);
      chk("R8 protection state", int'(prot_mon), (k <= 2) ? 1 : 0);
    end
    idle(7, "R8 hunting is quiet");
    step(1'b1, 1'b1);
    chk("R2 reacquire after release", int'(frame_strobe), 1);
    chk("R2 prot after reacquire", int'(prot_mon), 1);

    // R8 a good sync after one miss switches to the long limit
    h = WN / 2;
    do_reset(1'b0);
    step(1'b1, 1'b1);
    idle(FL + h - 2, "R8 quiet to first close");
    step(1'b1, 1'b0);
    chk("R8 first miss inserts", int'(frame_strobe), 1);
    idle(FL - h, "R8 quiet to nominal");
    step(1'b1, 1'b1);
    chk("R8 hit after miss", int'(sync_good), 1);
    for (int k = 1; k <= 3; k++) begin
      idle((k == 1) ? FL + h - 2 : FL - 1, "R7 quiet between closes");
      step(1'b1, 1'b0);
      chk("R7 third miss still inserts", int'(frame_strobe), 1);
      chk("R7 stays protected", int'(prot_mon), 1);
    end

    // R10 disabled cycles do not advance the frame counter
    do_reset(1'b0);
    step(1'b1, 1'b1);
    idle(10, "R10 quiet");
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      chk("R10 disabled sync ignored", int'(frame_strobe), 0);
    end
    idle(FL - 11, "R10 quiet");
    step(1'b1, 1'b1);
    chk("R10 nominal counts only enabled ticks", int'(frame_strobe), 1);
    chk("R10 good after gaps", int'(sync_good), 1);

    summary();
  end
endmodule